// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command pins of an SDRAM interface cycle by cycle and reports any command that the current bank states do not permit. It decodes the clock-enable, chip-select, row-strobe, column-strobe and write-enable pins into a command. It combines that command with a per-bank state vector supplied by the controller under test, and applies three kinds of rules. Some commands act on the whole device. Some act on the bank named by the bank address. The third rule guards the data bus when a write cuts into a read.

The first violation raises a sticky error flag and a small code that names the rule that was broken. Both stay until software or a testbench pulses the clear input. Checking is suspended while the clock enable is low or has just returned high. It also stays suspended for a programmable settling window after a self-refresh exit. The monitor drives nothing on the memory bus and can sit beside a controller in simulation or in silicon.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip-select low, the pins {ras_n,cas_n,we_n} decode as 011 activate, 101 read, 100 write, 010 precharge, 001 auto refresh, 000 mode load, 110 burst stop and 111 no-op. Chip-select high (deselect) is never flagged.
- R2: Commands are checked only when cke was high in the previous cycle and is high in the current cycle. With cke low in both cycles, no error is raised.
- R3: The cycle in which cke returns high is not checked. Neither are the following T_XSR cycles. The command in the next cycle after that is checked again.
- R4: Auto refresh and mode load are legal only when every bank reports Idle. The same applies to self-refresh entry, which is the auto refresh pin pattern in a cycle where cke falls. A violation gives code 2.
- R5: Burst stop is legal only when the addressed bank reports Read or Write. Otherwise it gives code 3.
- R6: Activate needs the addressed bank to be Idle. Read and write need it to be Row-active, Read or Write. Precharge is illegal while it is in Read-autoprecharge or Write-autoprecharge. A violation gives code 4. Reads and writes to one bank remain legal while other banks are bursting or auto-precharging.
- R7: A write issued while any bank is in Read or Read-autoprecharge is an error (code 5) unless dqm was high two cycles before the write.
- R8: Bank state codes per bank are Idle 0, Row-active 1, Read 2, Write 3, Read-autoprecharge 4 and Write-autoprecharge 5. Bank i uses bits [3i+2:3i]. Any bank reporting 6 or 7 during a checked, selected cycle gives code 1.
- R9: err_flag rises one clock after a violating command. It stays high, and err_code keeps the first violation's code, while later violations occur.
- R10: err_clr returns flag and code to zero on the next clock. If a violation occurs in that same cycle, the flag is set with that violation's code instead.
- R11: When one command breaks several rules, the lowest code is reported.
- R12: After reset, err_flag is 0 and err_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, same as the memory command clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_clr | input | 1 | Clears the sticky error |
| cke | input | 1 | Sampled clock enable |
| cs_n | input | 1 | Sampled chip select, active low |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write enable, active low |
| ba | input | BA_W | Sampled bank address |
| dqm | input | 1 | Sampled data mask |
| bank_state | input | 3*NUM_BANKS | Per-bank state codes from the controller |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violation |

## Verification
The bench aims at the edges of the gating window. It issues violations in the cke return cycle, through all T_XSR following cycles, and in the first cycle after the window. A monitor off by one would flag early or miss the first checked command. It also drives writes that interrupt reads with dqm high only one cycle early. A monitor that looks at the wrong history stage would accept or reject them wrongly.

Commands that break two rules at once check the priority, because a wrong order reports the wrong code. A second violation without a clear checks that the first code is held, so a monitor that overwrites it is caught. A clear coinciding with a violation shows whether the new error is lost.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

    localparam int ST_W  = 3;
    localparam int ERR_W = 3;

    typedef enum logic [3:0] {
        CMD_DESEL, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR,
        CMD_PRE, CMD_REF, CMD_LMR, CMD_BST
    } cmd_e;

    typedef enum logic [ST_W-1:0] {
        BS_IDLE = 3'd0,
        BS_ROW  = 3'd1,
        BS_RD   = 3'd2,
        BS_WR   = 3'd3,
        BS_RDAP = 3'd4,
        BS_WRAP = 3'd5
    } bank_st_e;

    // lower value wins when several rules break at once
    typedef enum logic [ERR_W-1:0] {
        ERR_NONE    = 3'd0,
        ERR_ENC     = 3'd1,
        ERR_ALLIDLE = 3'd2,
        ERR_BST     = 3'd3,
        ERR_STATE   = 3'd4,
        ERR_DQM     = 3'd5
    } err_e;

    typedef struct packed {
        logic flag;
        err_e code;
    } mon_s;

endpackage

// File: rtl/sdrc_cmd_decode.sv
module sdrc_cmd_decode
    import sdrc_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_LMR;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdrc_bank_view.sv
module sdrc_bank_view
    import sdrc_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS*ST_W-1:0] bank_state,
    input  logic [BA_W-1:0]           ba,
    output logic                      all_idle,
    output logic                      any_read,
    output logic                      any_bad,
    output bank_st_e                  tgt_st
);
    logic [NUM_BANKS-1:0] idle_v;
    logic [NUM_BANKS-1:0] read_v;
    logic [NUM_BANKS-1:0] bad_v;

    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
        logic [ST_W-1:0] st;
        assign st        = bank_state[gi*ST_W +: ST_W];
        assign idle_v[gi] = (st == BS_IDLE);
        assign read_v[gi] = (st == BS_RD) || (st == BS_RDAP);
        assign bad_v[gi]  = (st > BS_WRAP);
    end

    assign all_idle = &idle_v;
    assign any_read = |read_v;
    assign any_bad  = |bad_v;

    always_comb begin
        tgt_st = bank_st_e'(bank_state[int'(ba)*ST_W +: ST_W]);
    end
endmodule

// File: rtl/sdrc_gate.sv
module sdrc_gate #(
    parameter  int T_XSR = 8,
    localparam int CNT_W = $clog2(T_XSR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic dqm,
    output logic chk_en,
    output logic sref_en,
    output logic dqm_2ago
);
    typedef struct packed {
        logic             cke;
        logic [CNT_W-1:0] cnt;
        logic             dqm1;
        logic             dqm2;
    } gate_s;

    gate_s g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.cke  = cke;
        g_d.dqm1 = dqm;
        g_d.dqm2 = g_q.dqm1;
        if (!g_q.cke && cke) begin
            g_d.cnt = CNT_W'(T_XSR);
        end else if (g_q.cnt != '0) begin
            g_d.cnt = g_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{cke: 1'b1, cnt: '0, dqm1: 1'b1, dqm2: 1'b1};
        end else begin
            g_q <= g_d;
        end
    end

    assign chk_en   = g_q.cke && cke && (g_q.cnt == '0);
    assign sref_en  = g_q.cke && !cke && (g_q.cnt == '0);
    assign dqm_2ago = g_q.dqm2;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdrc_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int T_XSR     = 8,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      err_clr,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic                      dqm,
    input  logic [NUM_BANKS*ST_W-1:0] bank_state,
    output logic                      err_flag,
    output logic [ERR_W-1:0]          err_code
);
    cmd_e     cmd;
    logic     all_idle, any_read, any_bad;
    bank_st_e tgt_st;
    logic     chk_en, sref_en, dqm_2ago;

    sdrc_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
    );

    sdrc_bank_view #(.NUM_BANKS(NUM_BANKS)) u_view (
        .bank_state (bank_state),
        .ba         (ba),
        .all_idle   (all_idle),
        .any_read   (any_read),
        .any_bad    (any_bad),
        .tgt_st     (tgt_st)
    );

    sdrc_gate #(.T_XSR(T_XSR)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .dqm      (dqm),
        .chk_en   (chk_en),
        .sref_en  (sref_en),
        .dqm_2ago (dqm_2ago)
    );

    logic tgt_bad;
    always_comb begin
        unique case (cmd)
            CMD_ACT: tgt_bad = (tgt_st != BS_IDLE);
            CMD_RD,
            CMD_WR:  tgt_bad = !((tgt_st == BS_ROW) || (tgt_st == BS_RD) ||
                                 (tgt_st == BS_WR));
            CMD_PRE: tgt_bad = (tgt_st == BS_RDAP) || (tgt_st == BS_WRAP);
            default: tgt_bad = 1'b0;
        endcase
    end

    err_e viol;
    always_comb begin
        viol = ERR_NONE;
        if (chk_en && (cmd != CMD_DESEL)) begin
            if (any_bad) begin
                viol = ERR_ENC;
            end else if (((cmd == CMD_REF) || (cmd == CMD_LMR)) && !all_idle) begin
                viol = ERR_ALLIDLE;
            end else if ((cmd == CMD_BST) &&
                         !((tgt_st == BS_RD) || (tgt_st == BS_WR))) begin
                viol = ERR_BST;
            end else if (tgt_bad) begin
                viol = ERR_STATE;
            end else if ((cmd == CMD_WR) && any_read && !dqm_2ago) begin
                viol = ERR_DQM;
            end
        end else if (sref_en && (cmd == CMD_REF)) begin
            if (any_bad) begin
                viol = ERR_ENC;
            end else if (!all_idle) begin
                viol = ERR_ALLIDLE;
            end
        end
    end

    mon_s mon_d, mon_q;

    always_comb begin
        mon_d = mon_q;
        if ((viol != ERR_NONE) && (!mon_q.flag || err_clr)) begin
            mon_d.flag = 1'b1;
            mon_d.code = viol;
        end else if (err_clr) begin
            mon_d.flag = 1'b0;
            mon_d.code = ERR_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '{flag: 1'b0, code: ERR_NONE};
        end else begin
            mon_q <= mon_d;
        end
    end

    assign err_flag = mon_q.flag;
    assign err_code = mon_q.code;
endmodule

// File: rtl/sdrc_monitor_chk.sv
module sdrc_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       err_clr,
    input logic       cke,
    input logic       cs_n,
    input logic       err_flag,
    input logic [2:0] err_code
);
    logic cke_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cke_prev <= 1'b1;
        else        cke_prev <= cke;
    end

    // R9: once raised, flag and code hold until cleared
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> (err_flag && $stable(err_code)));

    // R9: a nonzero code exactly when the flag is up
    a_r9_flag_code_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag == (err_code != 3'd0)));

    // R2: cke low now and before means no new error
    a_r2_cke_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !cke && !cke_prev) |=> !err_flag);

    // R1: deselect never raises an error
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && cs_n) |=> !err_flag);

    // R10: clearing during a deselect always empties the flag
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && cs_n) |=> (!err_flag && (err_code == 3'd0)));
endmodule

bind sdram_cmd_monitor sdrc_monitor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_clr  (err_clr),
    .cke      (cke),
    .cs_n     (cs_n),
    .err_flag (err_flag),
    .err_code (err_code)
);

// File: tb/tb_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module tb_sdram_cmd_monitor;
    localparam int NB   = 4;
    localparam int TXSR = 8;

    localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                           P_PRE = 4'b0010, P_REF = 4'b0001, P_LMR = 4'b0000,
                           P_BST = 4'b0110, P_NOP = 4'b0111, P_DES = 4'b1111;
    localparam logic [2:0] I = 3'd0, A = 3'd1, R = 3'd2, W = 3'd3,
                           RA = 3'd4, WA = 3'd5;

    typedef struct packed {
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic        dqm;
        logic [11:0] st;   // {b3,b2,b1,b0}
        logic [2:0]  code;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{P_ACT, 2'd0, 1'b0, {I, I, I, I}, 3'd0, 4'd6},   // R6 activate idle
        '{P_ACT, 2'd1, 1'b0, {I, I, A, I}, 3'd4, 4'd6},   // R6 activate open bank
        '{P_RD,  2'd2, 1'b0, {I, A, I, I}, 3'd0, 4'd6},   // R6 read open bank
        '{P_RD,  2'd0, 1'b0, {I, I, I, I}, 3'd4, 4'd6},   // R6 read idle bank
        '{P_WR,  2'd1, 1'b1, {I, I, A, R}, 3'd0, 4'd7},   // R7 dqm early ok
        '{P_WR,  2'd1, 1'b0, {I, I, A, R}, 3'd5, 4'd7},   // R7 dqm missing
        '{P_WR,  2'd1, 1'b0, {I, I, A, RA}, 3'd5, 4'd7},  // R7 read autoprecharge
        '{P_WR,  2'd2, 1'b0, {I, A, I, W}, 3'd0, 4'd7},   // R7 write over write
        '{P_RD,  2'd3, 1'b0, {RA, I, I, I}, 3'd4, 4'd6},  // R6 read in autoprecharge
        '{P_RD,  2'd3, 1'b0, {A, I, I, WA}, 3'd0, 4'd6},  // R6 other bank autoprecharge
        '{P_WR,  2'd3, 1'b0, {A, I, I, WA}, 3'd0, 4'd6},  // R6 write other bank
        '{P_PRE, 2'd2, 1'b0, {I, WA, I, I}, 3'd4, 4'd6},  // R6 precharge in AP
        '{P_PRE, 2'd2, 1'b0, {I, I, I, I}, 3'd0, 4'd6},   // R6 precharge idle
        '{P_PRE, 2'd1, 1'b0, {I, I, R, I}, 3'd0, 4'd6},   // R6 precharge reading
        '{P_REF, 2'd0, 1'b0, {I, I, I, I}, 3'd0, 4'd4},   // R4 refresh idle
        '{P_REF, 2'd0, 1'b0, {A, I, I, I}, 3'd2, 4'd4},   // R4 refresh busy
        '{P_LMR, 2'd0, 1'b0, {I, I, R, I}, 3'd2, 4'd4},   // R4 mode load busy
        '{P_LMR, 2'd0, 1'b0, {I, I, I, I}, 3'd0, 4'd4},   // R4 mode load idle
        '{P_BST, 2'd0, 1'b0, {I, I, I, R}, 3'd0, 4'd5},   // R5 stop own burst
        '{P_BST, 2'd1, 1'b0, {I, I, A, R}, 3'd3, 4'd5},   // R5 stop other bank
        '{P_BST, 2'd2, 1'b0, {I, WA, I, I}, 3'd3, 4'd5},  // R5 stop AP bank
        '{P_NOP, 2'd0, 1'b0, {I, 3'd7, I, I}, 3'd1, 4'd8},// R8 bad code
        '{P_DES, 2'd0, 1'b0, {I, 3'd7, I, I}, 3'd0, 4'd1},// R1 deselect quiet
        '{P_NOP, 2'd0, 1'b0, {A, R, W, RA}, 3'd0, 4'd1},  // R1 nop quiet
        '{P_REF, 2'd0, 1'b0, {I, I, 3'd6, I}, 3'd1, 4'd11},// R11 enc beats all-idle
        '{P_WR,  2'd0, 1'b0, {I, I, R, I}, 3'd4, 4'd11}   // R11 state beats dqm
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_clr = 1'b0;
    logic cke = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic dqm = 1'b0;
    logic [11:0] st = '0;
    logic err_flag;
    logic [2:0] err_code;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(.NUM_BANKS(NB), .T_XSR(TXSR)) dut (
        .clk (clk), .rst_n (rst_n), .err_clr (err_clr), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .dqm (dqm), .bank_state (st),
        .err_flag (err_flag), .err_code (err_code)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pins(input logic [3:0] p);
        {cs_n, ras_n, cas_n, we_n} = p;
    endtask

    task automatic check(input string req, input logic [2:0] exp_code);
        n_chk++;
        if ((err_flag !== (exp_code != 3'd0)) || (err_code !== exp_code)) begin
            n_fail++;
            $display("FAIL %s: flag=%0b code=%0d, expected flag=%0b code=%0d",
                     req, err_flag, err_code, (exp_code != 3'd0), exp_code);
        end
    endtask

    task automatic clear();
        pins(P_DES); err_clr = 1'b1; step(); err_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(); step();
        check("R12 reset", 3'd0);
        rst_n = 1'b1;
        step();
        check("R12 after release", 3'd0);

        for (int i = 0; i < NV; i++) begin
            pins(P_DES); st = VECS[i].st; dqm = VECS[i].dqm; ba = VECS[i].ba;
            step(); dqm = 1'b0; step();
            pins(VECS[i].pins);
            step();
            check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].code);
            clear();
        end

        // R9: second violation does not replace the first code
        st = {I, I, I, A}; ba = 2'd0; pins(P_ACT); step();
        check("R9 first violation", 3'd4);
        pins(P_LMR); step();
        check("R9 code held", 3'd4);
        pins(P_DES); step(); step();
        check("R9 still held", 3'd4);

        // R10: clear, then clear with simultaneous violation
        clear();
        check("R10 cleared", 3'd0);
        pins(P_ACT); step();
        pins(P_LMR); err_clr = 1'b1; step(); err_clr = 1'b0;
        check("R10 clear with new violation", 3'd2);
        clear();

        // R2: cke low two cycles, violation ignored
        cke = 1'b0; pins(P_NOP); step();
        pins(P_LMR); step();
        check("R2 cke low", 3'd0);

        // R3: return cycle plus T_XSR cycles are ignored
        cke = 1'b1;
        for (int k = 0; k <= TXSR; k++) step();
        check("R3 window ignored", 3'd0);
        step();
        check("R3 checked after window", 3'd2);
        clear();

        // R4: self-refresh entry with a busy bank, then with all idle
        st = {I, I, I, A}; pins(P_DES); step();
        cke = 1'b0; pins(P_REF); step();
        check("R4 self refresh busy", 3'd2);
        clear();
        cke = 1'b1; st = '0;
        for (int k = 0; k < TXSR + 2; k++) step();
        cke = 1'b0; pins(P_REF); step();
        check("R4 self refresh idle", 3'd0);
        pins(P_DES); step();
        cke = 1'b1;
        for (int k = 0; k < TXSR + 2; k++) step();

        // R7: dqm high only one cycle before the write is not enough
        st = {I, I, A, R}; ba = 2'd1; dqm = 1'b0; step();
        dqm = 1'b1; step();
        dqm = 1'b0; pins(P_WR); step();
        check("R7 dqm one cycle early", 3'd5);
        clear();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule